// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

This block feeds a transmit frame assembler from a ring of two-word buffer descriptors in system memory. Software builds one or more descriptors per frame, gives each one to the hardware by clearing its ownership (used) bit, and then pulses a start control bit. The walker then fetches descriptors one after another. For each descriptor it presents the buffer address, the byte count and the frame flags as one segment on the assembly port. Consecutive segments belong to the same frame until a descriptor carrying the last-buffer flag closes it.

Each consumed descriptor gets its second word written back with the used bit set, which returns it to software. The walker keeps going through the ring until it fetches a descriptor that software has not handed over. If that happens in the middle of a frame, it tells the assembler to drop the partial frame. Frame completion is reported in two places: an interrupt status bit that is cleared when it is read, and a transmit status register whose bits are cleared by writing 1. Descriptor layout: word 0 is the buffer address. Word 1 holds the length in [13:0], last in bit 15, FCS-suppress in bit 16, wrap in bit 30 and used in bit 31.

Top module: `txdesc_walker`

## Requirements
- R1: For each descriptor with used bit 0, one segment is presented with seg_valid high for one cycle. On that segment, seg_addr equals word 0, seg_len equals word 1 bits [13:0], and seg_last equals word 1 bit 15.
- R2: Descriptors are fetched from the current ring pointer, and the pointer advances by 8 bytes per consumed descriptor. Word 0 is read at the pointer and word 1 at pointer + 4. Writing the ring base register (address 1) while idle loads the pointer with that value, with bits [2:0] cleared.
- R3: After a descriptor with word 1 bit 30 (wrap) set is consumed, the next fetch reads from the ring base address.
- R4: Each consumed descriptor has word 1 rewritten at pointer + 4 with bit 31 set and all other bits unchanged. Word 0 is never written.
- R5: A fetched descriptor with bit 31 already set emits no segment and sets transmit status bit 1 (used-bit read). The pointer stays on that descriptor, and the walker stays idle until the next start.
- R6: If a used descriptor is fetched after a non-last segment of the same frame, seg_abort pulses for one cycle, and no completion is reported for that frame.
- R7: seg_nofcs equals word 1 bit 16 on the last segment of a frame and is 0 on every other segment.
- R8: Writing 1 to bit 0 of the control register (address 0) starts the walk. A start written while the walker is busy is ignored.
- R9: The cycle after a last segment, interrupt status bit 0 (address 2) is set and irq is high. A read of address 2 returns the old value and clears the bit, but a completion in the same cycle as the read wins.
- R10: Transmit status (address 3) bit 0 records frame completion and bit 1 records a used-bit stop. Writing 1 to a bit clears it, but a new event in the same cycle wins.
- R11: After reset, irq, seg_valid, seg_abort and mem_req are 0, both status registers read 0, and the ring pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 ring base, 2 interrupt status, 3 transmit status |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data, valid the cycle after reg_rd |
| irq | output | 1 | Transmit-complete interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | W | Memory byte address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Memory read data, one cycle after a read request |
| seg_valid | output | 1 | Segment strobe to the frame assembler |
| seg_addr | output | W | Buffer address of the segment |
| seg_len | output | LEN_W | Byte count of the segment |
| seg_last | output | 1 | Segment closes the frame |
| seg_nofcs | output | 1 | Frame carries its own FCS |
| seg_abort | output | 1 | Discard the partially assembled frame |

## Verification
Two pairs of events can land in the same cycle. The first pair is the completion of a frame and a software read of the interrupt status. The second pair is the completion and a write-1-to-clear of the transmit status. The bench waits until it sees a last segment on the assembly port and drives the read, or the clearing write, in that very cycle. It then judges the outcome: the read must return the old value 0, irq must stay high, and the complete bit must still read as 1 afterwards.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;
  // Descriptor geometry
  localparam int DESC_BYTES = 8;
  localparam int WORD_BYTES = 4;

  // Word 1 control field positions
  localparam int LAST_BIT  = 15;
  localparam int NOFCS_BIT = 16;
  localparam int WRAP_BIT  = 30;
  localparam int USED_BIT  = 31;

  // Register map
  typedef enum logic [1:0] {
    RA_CTRL = 2'd0,
    RA_BASE = 2'd1,
    RA_ISR  = 2'd2,
    RA_TSR  = 2'd3
  } reg_addr_e;

  // Fetch sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD1,
    ST_CAP0,
    ST_EVAL,
    ST_WBACK
  } fetch_st_e;
endpackage

// File: rtl/txdesc_regs.sv
module txdesc_regs
  import txdesc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [1:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         ev_done,
  input  logic         ev_usedrd,
  output logic         start_pls,
  output logic         base_pls,
  output logic [W-1:0] base_addr,
  output logic         irq
);
  logic       isr_q;
  logic [1:0] tsr_q;
  logic       rd_isr;
  logic       wr_tsr;
  logic [1:0] tsr_clr;

  assign rd_isr  = reg_rd && (reg_addr == RA_ISR);
  assign wr_tsr  = reg_wr && (reg_addr == RA_TSR);
  assign tsr_clr = wr_tsr ? reg_wdata[1:0] : 2'b00;
  assign irq     = isr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q     <= 1'b0;
      tsr_q     <= 2'b00;
      base_addr <= '0;
      start_pls <= 1'b0;
      base_pls  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      start_pls <= reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0];
      base_pls  <= reg_wr && (reg_addr == RA_BASE);
      if (reg_wr && (reg_addr == RA_BASE))
        base_addr <= reg_wdata & ~W'(DESC_BYTES - 1);
      // event set takes priority over software clear
      isr_q    <= (isr_q & ~rd_isr) | ev_done;
      tsr_q[0] <= (tsr_q[0] & ~tsr_clr[0]) | ev_done;
      tsr_q[1] <= (tsr_q[1] & ~tsr_clr[1]) | ev_usedrd;
      if (reg_rd) begin
        case (reg_addr)
          RA_CTRL: reg_rdata <= '0;
          RA_BASE: reg_rdata <= base_addr;
          RA_ISR:  reg_rdata <= {{(W-1){1'b0}}, isr_q};
          RA_TSR:  reg_rdata <= {{(W-2){1'b0}}, tsr_q};
          default: reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/txdesc_ptr.sv
module txdesc_ptr
  import txdesc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] base_addr,
  input  logic         advance,
  input  logic         wrap,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] STEP = W'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (load)
      ptr <= base_addr;
    else if (advance)
      ptr <= wrap ? base_addr : ptr + STEP;
  end
endmodule

// File: rtl/txdesc_fetch.sv
module txdesc_fetch
  import txdesc_pkg::*;
#(
  parameter int W     = 32,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [W-1:0]     ptr,
  output logic             idle,
  output logic             advance,
  output logic             wrap,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  output logic             seg_valid,
  output logic [W-1:0]     seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             seg_last,
  output logic             seg_nofcs,
  output logic             seg_abort,
  output logic             ev_done,
  output logic             ev_usedrd
);
  localparam logic [W-1:0] W1_OFS = W'(WORD_BYTES);

  fetch_st_e    state;
  logic [W-1:0] w0_q;
  logic         in_frame;
  logic         d_used;
  logic         d_last;

  assign d_used  = mem_rdata[USED_BIT];
  assign d_last  = mem_rdata[LAST_BIT];
  assign idle    = (state == ST_IDLE);
  assign advance = (state == ST_EVAL) && !d_used;
  assign wrap    = mem_rdata[WRAP_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      w0_q      <= '0;
      in_frame  <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      seg_valid <= 1'b0;
      seg_addr  <= '0;
      seg_len   <= '0;
      seg_last  <= 1'b0;
      seg_nofcs <= 1'b0;
      seg_abort <= 1'b0;
      ev_done   <= 1'b0;
      ev_usedrd <= 1'b0;
    end else begin
      seg_valid <= 1'b0;
      seg_abort <= 1'b0;
      ev_done   <= 1'b0;
      ev_usedrd <= 1'b0;
      case (state)
        ST_IDLE: begin
          mem_req <= 1'b0;
          mem_we  <= 1'b0;
          if (start) begin
            mem_req  <= 1'b1;
            mem_addr <= ptr;
            state    <= ST_RD1;
          end
        end
        ST_RD1: begin
          // word 0 request is on the bus; queue word 1
          mem_addr <= ptr + W1_OFS;
          state    <= ST_CAP0;
        end
        ST_CAP0: begin
          w0_q    <= mem_rdata;
          mem_req <= 1'b0;
          state   <= ST_EVAL;
        end
        ST_EVAL: begin
          if (d_used) begin
            ev_usedrd <= 1'b1;
            seg_abort <= in_frame;
            in_frame  <= 1'b0;
            state     <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= ptr + W1_OFS;
            mem_wdata <= mem_rdata | (W'(1) << USED_BIT);
            seg_valid <= 1'b1;
            seg_addr  <= w0_q;
            seg_len   <= mem_rdata[LEN_W-1:0];
            seg_last  <= d_last;
            seg_nofcs <= d_last && mem_rdata[NOFCS_BIT];
            ev_done   <= d_last;
            in_frame  <= !d_last;
            state     <= ST_WBACK;
          end
        end
        ST_WBACK: begin
          // pointer already advanced; read next word 0
          mem_we   <= 1'b0;
          mem_req  <= 1'b1;
          mem_addr <= ptr;
          state    <= ST_RD1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txdesc_walker.sv
module txdesc_walker
  import txdesc_pkg::*;
#(
  parameter int W     = 32,
  parameter int LEN_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [1:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic             irq,
  output logic             mem_req,
  output logic             mem_we,
  output logic [W-1:0]     mem_addr,
  output logic [W-1:0]     mem_wdata,
  input  logic [W-1:0]     mem_rdata,
  output logic             seg_valid,
  output logic [W-1:0]     seg_addr,
  output logic [LEN_W-1:0] seg_len,
  output logic             seg_last,
  output logic             seg_nofcs,
  output logic             seg_abort
);
  logic         start_pls;
  logic         base_pls;
  logic [W-1:0] base_addr;
  logic [W-1:0] ptr;
  logic         idle;
  logic         advance;
  logic         wrap;
  logic         ev_done;
  logic         ev_usedrd;

  txdesc_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ev_done   (ev_done),
    .ev_usedrd (ev_usedrd),
    .start_pls (start_pls),
    .base_pls  (base_pls),
    .base_addr (base_addr),
    .irq       (irq)
  );

  txdesc_ptr #(.W(W)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .load      (base_pls && idle),
    .base_addr (base_addr),
    .advance   (advance),
    .wrap      (wrap),
    .ptr       (ptr)
  );

  txdesc_fetch #(.W(W), .LEN_W(LEN_W)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start     (start_pls),
    .ptr       (ptr),
    .idle      (idle),
    .advance   (advance),
    .wrap      (wrap),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .seg_valid (seg_valid),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_last  (seg_last),
    .seg_nofcs (seg_nofcs),
    .seg_abort (seg_abort),
    .ev_done   (ev_done),
    .ev_usedrd (ev_usedrd)
  );
endmodule

// File: rtl/txdesc_walker_chk.sv
module txdesc_walker_chk #(
  parameter int W     = 32,
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [1:0]       reg_addr,
  input logic [W-1:0]     reg_wdata,
  input logic [W-1:0]     reg_rdata,
  input logic             irq,
  input logic             mem_req,
  input logic             mem_we,
  input logic [W-1:0]     mem_addr,
  input logic [W-1:0]     mem_wdata,
  input logic [W-1:0]     mem_rdata,
  input logic             seg_valid,
  input logic [W-1:0]     seg_addr,
  input logic [LEN_W-1:0] seg_len,
  input logic             seg_last,
  input logic             seg_nofcs,
  input logic             seg_abort
);
  a_r9_irq_after_last: assert property (@(posedge clk) disable iff (rst)
    seg_valid && seg_last |=> irq);

  a_r9_irq_holds: assert property (@(posedge clk) disable iff (rst)
    irq && !(reg_rd && reg_addr == 2'd2) |=> irq);

  a_r6_abort_alone: assert property (@(posedge clk) disable iff (rst)
    !(seg_abort && seg_valid));

  a_r4_wb_sets_used: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata[31]);

  a_r4_wb_word1_only: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_addr[2:0] == 3'd4);

  a_r1_seg_with_wb: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> mem_req && mem_we);

  a_r2_aligned_read: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> mem_addr[1:0] == 2'b00);

  a_r7_nofcs_last_only: assert property (@(posedge clk) disable iff (rst)
    seg_valid && !seg_last |-> !seg_nofcs);
endmodule

bind txdesc_walker txdesc_walker_chk #(.W(W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/test_txdesc_walker.sv
`timescale 1ns/1ps
module test_txdesc_walker;
  localparam int W = 32;
  localparam int LEN_W = 14;
  localparam logic [31:0] LAST  = 32'h0000_8000;
  localparam logic [31:0] NOFCS = 32'h0001_0000;
  localparam logic [31:0] WRAP  = 32'h4000_0000;
  localparam logic [31:0] USED  = 32'h8000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic             reg_wr = 0, reg_rd = 0;
  logic [1:0]       reg_addr = 0;
  logic [W-1:0]     reg_wdata = 0;
  logic [W-1:0]     reg_rdata;
  logic             irq;
  logic             mem_req, mem_we;
  logic [W-1:0]     mem_addr, mem_wdata;
  logic [W-1:0]     mem_rdata;
  logic             seg_valid, seg_last, seg_nofcs, seg_abort;
  logic [W-1:0]     seg_addr;
  logic [LEN_W-1:0] seg_len;

  txdesc_walker #(.W(W), .LEN_W(LEN_W)) i_txdesc_walker (.*);

  // memory model with a bench write port
  logic [31:0] mem [0:63];
  logic        tb_we = 0;
  logic [5:0]  tb_widx = 0;
  logic [31:0] tb_wdat = 0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_widx] <= tb_wdat;
    else if (mem_req && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[7:2]];
  end

  int checks = 0, errors = 0, aborts = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [13:0] l;
    logic        last;
    logic        nofcs;
  } seg_t;
  seg_t exp_q[$];

  task automatic expect_seg(input logic [31:0] a, input logic [13:0] l, input logic last, input logic nofcs);
    exp_q.push_back('{a, l, last, nofcs});
  endtask

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (!rst && seg_abort) aborts++;
    if (!rst && seg_valid) begin
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected segment", seg_addr, 32'h0);
      end else begin
        seg_t e;
        e = exp_q.pop_front();
        check(seg_addr == e.a, "R1 seg_addr", seg_addr, e.a);
        check(seg_len == e.l, "R1 seg_len", {18'h0, seg_len}, {18'h0, e.l});
        check(seg_last == e.last, "R1 seg_last", {31'h0, seg_last}, {31'h0, e.last});
        check(seg_nofcs == e.nofcs, "R7 seg_nofcs", {31'h0, seg_nofcs}, {31'h0, e.nofcs});
      end
    end
  end

  task automatic put_word(input logic [7:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1; tb_widx = byte_addr[7:2]; tb_wdat = d;
    @(negedge clk);
    tb_we = 0;
  endtask

  task automatic put_desc(input logic [7:0] a, input logic [31:0] w0, input logic [31:0] w1);
    put_word(a, w0);
    put_word(a + 8'd4, w1);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic clear_status();
    logic [31:0] d;
    reg_read(2'd2, d);
    reg_write(2'd3, 32'h3);
  endtask

  initial begin
    logic [31:0] d;
    int ab0;
    for (int i = 0; i < 64; i++) put_word(8'(i * 4), USED);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R11 reset state
    check(irq == 0, "R11 irq", {31'h0, irq}, 0);
    check(seg_valid == 0 && seg_abort == 0, "R11 seg strobes", {30'h0, seg_valid, seg_abort}, 0);
    check(mem_req == 0, "R11 mem_req", {31'h0, mem_req}, 0);
    reg_read(2'd3, d); check(d == 0, "R11 tsr", d, 0);
    reg_read(2'd2, d); check(d == 0, "R11 isr", d, 0);

    // Two-buffer frame from pointer 0 (R1 R2 R4 R7 R8), stop on used (R5)
    put_desc(8'h00, 32'h1000, 32'd14 | NOFCS);
    put_desc(8'h08, 32'h2000, 32'd986 | LAST | NOFCS);
    put_desc(8'h10, 32'h2400, 32'd5 | USED);
    expect_seg(32'h1000, 14'd14, 1'b0, 1'b0);
    expect_seg(32'h2000, 14'd986, 1'b1, 1'b1);
    reg_write(2'd0, 32'h1);
    reg_write(2'd0, 32'h1); // R8 start while busy ignored
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R2 segments delivered", exp_q.size(), 0);
    check(aborts == 0, "R6 no abort on clean stop", aborts, 0);
    check(irq == 1, "R9 irq raised", {31'h0, irq}, 1);
    check(mem[1] == (32'd14 | NOFCS | USED), "R4 writeback d0", mem[1], 32'd14 | NOFCS | USED);
    check(mem[3] == (32'd986 | LAST | NOFCS | USED), "R4 writeback d1", mem[3], 32'd986 | LAST | NOFCS | USED);
    check(mem[2] == 32'h2000, "R4 word0 untouched", mem[2], 32'h2000);
    check(mem[5] == (32'd5 | USED), "R5 used desc untouched", mem[5], 32'd5 | USED);
    reg_read(2'd3, d); check(d == 32'h3, "R10 tsr complete+usedread", d, 3);
    reg_read(2'd2, d); check(d == 32'h1, "R9 isr read", d, 1);
    check(irq == 0, "R9 read clears irq", {31'h0, irq}, 0);
    reg_read(2'd2, d); check(d == 32'h0, "R9 isr cleared", d, 0);
    reg_write(2'd3, 32'h1);
    reg_read(2'd3, d); check(d == 32'h2, "R10 w1c bit0", d, 2);
    reg_write(2'd3, 32'h2);
    reg_read(2'd3, d); check(d == 32'h0, "R10 w1c bit1", d, 0);
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R5 idle after stop", exp_q.size(), 0);

    // Ring wrap (R3)
    reg_write(2'd1, 32'h40);
    put_desc(8'h40, 32'h3000, 32'd100 | NOFCS);
    put_desc(8'h48, 32'h3100, 32'd200 | LAST | WRAP);
    put_desc(8'h50, 32'h3200, 32'd9 | LAST);
    expect_seg(32'h3000, 14'd100, 1'b0, 1'b0);
    expect_seg(32'h3100, 14'd200, 1'b1, 1'b0);
    reg_write(2'd0, 32'h1);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R3 wrap frame delivered", exp_q.size(), 0);
    reg_read(2'd3, d); check(d == 32'h3, "R5 stop at base after wrap", d, 3);
    clear_status();
    put_desc(8'h40, 32'h5000, 32'd7 | LAST | WRAP);
    expect_seg(32'h5000, 14'd7, 1'b1, 1'b0);
    reg_write(2'd0, 32'h1);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R3 restart reads ring base", exp_q.size(), 0);
    check(mem[8'h54 >> 2] == (32'd9 | LAST), "R3 descriptor past wrap unread", mem[8'h54 >> 2], 32'd9 | LAST);
    clear_status();

    // Mid-frame used descriptor (R6)
    reg_write(2'd1, 32'h80);
    put_desc(8'h80, 32'h6000, 32'd50);
    put_desc(8'h88, 32'h6100, 32'd60 | LAST | USED);
    expect_seg(32'h6000, 14'd50, 1'b0, 1'b0);
    ab0 = aborts;
    reg_write(2'd0, 32'h1);
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R6 first segment sent", exp_q.size(), 0);
    check(aborts == ab0 + 1, "R6 abort pulse", aborts, ab0 + 1);
    check(irq == 0, "R6 no completion irq", {31'h0, irq}, 0);
    reg_read(2'd3, d); check(d == 32'h2, "R6 only usedread status", d, 2);
    clear_status();

    // Same-cycle collisions (R9 R10)
    reg_write(2'd1, 32'hC0);
    put_desc(8'hC0, 32'h7000, 32'd60 | LAST);
    put_desc(8'hC8, 32'h7100, 32'd61 | LAST);
    put_desc(8'hD0, 32'h7200, 32'd62 | USED);
    expect_seg(32'h7000, 14'd60, 1'b1, 1'b0);
    expect_seg(32'h7100, 14'd61, 1'b1, 1'b0);
    reg_write(2'd0, 32'h1);
    do @(negedge clk); while (!(seg_valid && seg_last));
    reg_rd = 1; reg_addr = 2'd2;
    @(negedge clk);
    reg_rd = 0;
    check(reg_rdata == 0, "R9 read returns pre-event value", reg_rdata, 0);
    check(irq == 1, "R9 set wins over read clear", {31'h0, irq}, 1);
    do @(negedge clk); while (!(seg_valid && seg_last));
    reg_wr = 1; reg_addr = 2'd3; reg_wdata = 32'h1;
    @(negedge clk);
    reg_wr = 0;
    reg_read(2'd3, d); check(d[0] == 1'b1, "R10 set wins over w1c", d, 1);
    repeat (30) @(negedge clk);
    check(exp_q.size() == 0, "R1 collision frames delivered", exp_q.size(), 0);
    reg_read(2'd3, d); check(d == 32'h3, "R10 final status", d, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule